// File: doc/BRIEF.md
# Watchdog Timer with Keyed Refresh

This peripheral sits on a small 8-bit register bus and guards a microcontroller against runaway software. An 8-bit down counter, paced by a selectable counting clock and a programmable prescaler, must be refreshed before it runs out. If it runs out, the block issues a one-cycle chip reset request. The refresh is not a single write. It is a keyed pair of writes: 0xA5 to the first key port, then 0x5A to the second key port. Any break in that pair is itself treated as a fault and requests reset.

Changes to the control register are guarded the same way. The next bus write after a control write must begin a valid refresh. Otherwise the block faults. New control settings and the reload value reach the counting logic only when a refresh completes. The active settings are copied into a shadow set at that moment. The three counting sources are the slow on-chip oscillator, the bus clock and a crystal oscillator. They arrive as single-cycle clock-enable pulses in the block's own clock domain.

After a watchdog reset, the block returns to its power-on state. The one exception is the timeout flag, which stays set so that software can find out why the chip restarted.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset, `wdt_reset` is low, CTRL reads 0x00, RELOAD reads 0xFF and COUNT reads 0xFF.
- R2: Register map on `bus_addr`: 0 = CTRL, 1 = RELOAD, 2 = first key port, 3 = second key port, 4 = COUNT (read-only). CTRL bits: bit0 run, bit1 timeout flag, bits 4:2 prescaler select PRE, bits 6:5 source select, bit7 reads 0.
- R3: A valid refresh is a write of 0xA5 to address 2, with the next bus write being 0x5A to address 3. Idle cycles between the two writes are allowed. The refresh loads COUNT from RELOAD, clears the prescaler and makes the CTRL settings active.
- R4: With run active, the reset pulse appears exactly (RELOAD+1) × 2^(PRE+1+DIV_BASE_LOG2) selected ticks after the refresh.
- R5: Source select 00 counts `tick_slow`, 01 counts `tick_bus`, and 10 or 11 count `tick_xtal`. Unselected ticks have no effect.
- R6: With the active run bit at 0, COUNT holds its value and no timeout occurs.
- R7: Each of these writes raises `wdt_reset` in the cycle after the write: a write to address 2 with data other than 0xA5; a write to address 3 that does not directly follow 0xA5 at address 2; and, after 0xA5, any write other than 0x5A to address 3.
- R8: After a CTRL write, the next write must be 0xA5 to address 2, followed by a valid completion. Otherwise reset is requested. The CTRL readback changes at once, but counting uses the new settings only after the refresh.
- R9: The reset request lasts exactly one cycle. Bus writes during that cycle are ignored.
- R10: A watchdog reset returns the block to its R1 state, except that the timeout flag is set (CTRL reads 0x02).
- R11: Writing 0 to CTRL bit1 clears the timeout flag. Writing 1 leaves it unchanged. Power-on reset also clears it.
- R12: A RELOAD write while counting does not change the current countdown. It takes effect at the next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_slow | input | 1 | Enable pulse from the slow on-chip oscillator |
| tick_bus | input | 1 | Enable pulse from the bus clock |
| tick_xtal | input | 1 | Enable pulse from the crystal oscillator |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| wdt_reset | output | 1 | One-cycle chip reset request |

## Verification
The bench builds the block with DIV_BASE_LOG2 = 0, so one counter step takes between 2 and 256 ticks instead of 64 to 8192. This makes it possible to sweep all eight prescaler codes against several reload values, including zero and full scale, and to compare each timeout exactly with (RELOAD+1) × 2^(PRE+1). The same reduced configuration keeps source-select runs and mid-count reload writes short, while the key-sequence faults and flag behaviour are exercised one case at a time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_KEY1   = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEY2   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;

    localparam logic [DATA_W-1:0] KEY1_VAL = 8'hA5;
    localparam logic [DATA_W-1:0] KEY2_VAL = 8'h5A;

    // Control register image; packed MSB first: src[6:5], pre[4:2], tof[1], run[0]
    typedef struct packed {
        logic [1:0] src;
        logic [2:0] pre;
        logic       tof;
        logic       run;
    } ctrl_t;

    // Settings copied to the counting side at refresh time
    typedef struct packed {
        logic [1:0] src;
        logic [2:0] pre;
        logic       run;
    } cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_CTRL_WAIT = 2'd1,
        SEQ_HALF      = 2'd2
    } seq_e;

    function automatic cfg_t cfg_of(ctrl_t c);
        cfg_t r;
        r.src = c.src;
        r.pre = c.pre;
        r.run = c.run;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_byte(ctrl_t c);
        return {1'b0, c};
    endfunction

    // New control image from a bus write: flag may only be cleared
    function automatic ctrl_t ctrl_write(ctrl_t cur, logic [DATA_W-1:0] d);
        ctrl_t r;
        r.src = d[6:5];
        r.pre = d[4:2];
        r.tof = cur.tof & d[1];
        r.run = d[0];
        return r;
    endfunction

    function automatic ctrl_t ctrl_after_fault();
        ctrl_t r;
        r     = '0;
        r.tof = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/wdt_seq.sv
module wdt_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hold,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              feed_ok,
    output logic              feed_bad
);

    seq_e state_q, state_d;
    logic wr_live;

    assign wr_live = wr && !hold;

    always_comb begin
        state_d  = state_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        if (wr_live) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (addr == A_CTRL) begin
                        state_d = SEQ_CTRL_WAIT;
                    end else if (addr == A_KEY1) begin
                        if (wdata == KEY1_VAL) state_d = SEQ_HALF;
                        else                   feed_bad = 1'b1;
                    end else if (addr == A_KEY2) begin
                        feed_bad = 1'b1;
                    end
                end
                SEQ_CTRL_WAIT: begin
                    if (addr == A_KEY1 && wdata == KEY1_VAL) state_d = SEQ_HALF;
                    else                                     feed_bad = 1'b1;
                end
                SEQ_HALF: begin
                    if (addr == A_KEY2 && wdata == KEY2_VAL) begin
                        feed_ok = 1'b1;
                        state_d = SEQ_IDLE;
                    end else begin
                        feed_bad = 1'b1;
                    end
                end
                default: feed_bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) state_q <= SEQ_IDLE;
        else              state_q <= state_d;
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int DIV_BASE_LOG2 = 5
)(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick_slow,
    input  logic tick_bus,
    input  logic tick_xtal,
    input  cfg_t cfg,
    output logic step
);

    localparam int PW = DIV_BASE_LOG2 + 9;

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] limit;
    logic          sel_tick;
    logic          advance;

    always_comb begin
        unique case (cfg.src)
            2'b00:   sel_tick = tick_slow;
            2'b01:   sel_tick = tick_bus;
            default: sel_tick = tick_xtal;
        endcase
    end

    // Division 2^(PRE+1+base): terminal prescaler count is that minus one
    assign limit   = (PW'(1) << (DIV_BASE_LOG2 + 1 + int'(cfg.pre))) - PW'(1);
    assign advance = cfg.run && sel_tick;
    assign step    = advance && (pcnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear)  pcnt_q <= '0;
        else if (advance)  pcnt_q <= step ? '0 : pcnt_q + PW'(1);
    end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter logic [DATA_W-1:0] RELOAD_INIT = 8'hFF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              load,
    input  logic [DATA_W-1:0] reload_val,
    input  cfg_t              cfg_next,
    input  logic              step,
    output cfg_t              cfg_act,
    output logic [DATA_W-1:0] count,
    output logic              underflow
);

    assign underflow = step && (count == '0);

    always_ff @(posedge clk) begin
        if (rst || fire) begin
            count   <= RELOAD_INIT;
            cfg_act <= '0;
        end else if (load) begin
            count   <= reload_val;
            cfg_act <= cfg_next;
        end else if (step) begin
            count   <= count - DATA_W'(1);
        end
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int                DIV_BASE_LOG2 = 5,
    parameter logic [DATA_W-1:0] RELOAD_INIT   = 8'hFF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_slow,
    input  logic              tick_bus,
    input  logic              tick_xtal,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              feed_ok, feed_bad, underflow, fire, step, wr_live;
    cfg_t              cfg_act;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] ctrl_rd;

    assign fire    = feed_bad || underflow;
    assign wr_live = bus_wr && !wdt_reset;
    assign ctrl_rd = ctrl_byte(ctrl_q);

    wdt_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .clear    (fire),
        .hold     (wdt_reset),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdt_prescale #(.DIV_BASE_LOG2(DIV_BASE_LOG2)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .clear     (feed_ok || fire),
        .tick_slow (tick_slow),
        .tick_bus  (tick_bus),
        .tick_xtal (tick_xtal),
        .cfg       (cfg_act),
        .step      (step)
    );

    wdt_countdown #(.RELOAD_INIT(RELOAD_INIT)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .load       (feed_ok),
        .reload_val (reload_q),
        .cfg_next   (cfg_of(ctrl_q)),
        .step       (step),
        .cfg_act    (cfg_act),
        .count      (count),
        .underflow  (underflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            reload_q  <= RELOAD_INIT;
            wdt_reset <= 1'b0;
        end else begin
            wdt_reset <= fire;
            if (fire) begin
                ctrl_q   <= ctrl_after_fault();
                reload_q <= RELOAD_INIT;
            end else if (wr_live) begin
                if (bus_addr == A_CTRL)   ctrl_q   <= ctrl_write(ctrl_q, bus_wdata);
                if (bus_addr == A_RELOAD) reload_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_rd;
            A_RELOAD: bus_rdata = reload_q;
            A_COUNT:  bus_rdata = count;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wdt_reset,
    input logic [DATA_W-1:0] ctrl_rd,
    input logic              run_act,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload_q,
    input logic              feed_ok,
    input logic              underflow
);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |=> !wdt_reset);

    assert_bad_key1_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !wdt_reset && bus_addr == A_KEY1 && bus_wdata != KEY1_VAL) |=> wdt_reset);

    assert_flag_after_fault_R10: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> (ctrl_rd == 8'h02));

    assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_act && !bus_wr) |=> $stable(count));

    assert_refresh_loads_R3: assert property (@(posedge clk) disable iff (rst)
        (feed_ok && !underflow) |=> (count == $past(reload_q)));

    assert_underflow_fires_R4: assert property (@(posedge clk) disable iff (rst)
        underflow |=> wdt_reset);

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wdt_reset (wdt_reset),
    .ctrl_rd   (ctrl_rd),
    .run_act   (cfg_act.run),
    .count     (count),
    .reload_q  (reload_q),
    .feed_ok   (feed_ok),
    .underflow (underflow)
);

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_slow = 1'b0, tick_bus = 1'b1, tick_xtal = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wdt_reset;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    wdt_guard #(.DIV_BASE_LOG2(0), .RELOAD_INIT(8'hFF)) dut (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_bus(tick_bus),
        .tick_xtal(tick_xtal), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset(wdt_reset)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic refresh();
        wr(3'd2, 8'hA5);
        wr(3'd3, 8'h5A);
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    // Counts negedges until the pulse is seen; pulse must end one cycle later
    task automatic measure(input int exp, input string req);
        int n = 0;
        bit got = 0;
        while (!got && n < exp + 50) begin
            @(negedge clk);
            n++;
            if (wdt_reset) got = 1;
        end
        check(got && n == exp, req, n, exp);
        @(negedge clk);
        check(wdt_reset == 1'b0, "R9 pulse width", wdt_reset, 0);
    endtask

    task automatic quiet(input int cycles, input string req);
        bit seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wdt_reset) seen = 1;
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic fault_now(input string req);
        check(wdt_reset == 1'b1, req, wdt_reset, 1);
        @(negedge clk);
        check(wdt_reset == 1'b0, "R9 pulse width", wdt_reset, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(wdt_reset == 1'b0, "R1 reset out", wdt_reset, 0);
        expect_reg(3'd0, 8'h00, "R1 CTRL");
        expect_reg(3'd1, 8'hFF, "R1 RELOAD");
        expect_reg(3'd4, 8'hFF, "R1 COUNT");

        // R4 / R2: sweep every prescaler code against several reload values
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 3; k++) begin
                int rl = (k == 0) ? 0 : ((k == 1) ? 3 : 9);
                wr(3'd1, 8'(rl));
                wr(3'd0, {1'b0, 2'b01, 3'(p), 1'b0, 1'b1});
                refresh();
                // two negedges of the refresh are already past the loading edge by one
                measure((rl + 1) * (1 << (p + 1)), "R4 timeout period");
                expect_reg(3'd0, 8'h02, "R10 CTRL after timeout");
                expect_reg(3'd1, 8'hFF, "R10 RELOAD after timeout");
                expect_reg(3'd4, 8'hFF, "R10 COUNT after timeout");
            end
        end
        // R4 full-scale reload
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h21);
        refresh();
        measure(256 * 2, "R4 full reload");

        // R11: writing 1 keeps the flag, writing 0 clears it
        wr(3'd0, 8'h02);
        refresh();
        check(wdt_reset == 1'b0, "R11 refresh ok", wdt_reset, 0);
        expect_reg(3'd0, 8'h02, "R11 flag kept");
        wr(3'd0, 8'h00);
        refresh();
        expect_reg(3'd0, 8'h00, "R11 flag cleared");

        // R5: slow source with no ticks does not count
        tick_bus = 1'b0;
        wr(3'd0, 8'h01);
        refresh();
        quiet(300, "R5 unselected ticks ignored");
        expect_reg(3'd4, 8'hFF, "R5 COUNT frozen");
        @(negedge clk);
        tick_slow = 1'b1;
        measure(512, "R5 slow source");
        tick_slow = 1'b0;
        tick_xtal = 1'b1;
        wr(3'd1, 8'd4);
        wr(3'd0, 8'h41);
        refresh();
        measure(10, "R5 xtal source code 10");
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h61);
        refresh();
        measure(6, "R5 xtal source code 11");
        tick_xtal = 1'b0;
        tick_bus  = 1'b1;

        // R6: run bit clear keeps COUNT
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h20);
        refresh();
        quiet(50, "R6 no timeout when stopped");
        expect_reg(3'd4, 8'd2, "R6 COUNT held");

        // R7 key faults
        wr(3'd2, 8'h55);
        fault_now("R7 wrong first key");
        wr(3'd3, 8'h5A);
        fault_now("R7 second key without first");
        wr(3'd2, 8'hA5);
        wr(3'd1, 8'h10);
        fault_now("R7 other write between keys");
        expect_reg(3'd1, 8'hFF, "R7 RELOAD not written");
        wr(3'd2, 8'hA5);
        wr(3'd3, 8'h5B);
        fault_now("R7 wrong second key");

        // R8: control write must be followed by refresh
        wr(3'd0, 8'h01);
        wr(3'd1, 8'h07);
        fault_now("R8 control write not followed by refresh");
        expect_reg(3'd0, 8'h02, "R8 CTRL after fault");
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h29);
        expect_reg(3'd0, 8'h29, "R8 CTRL readback before refresh");
        expect_reg(3'd4, 8'hFF, "R8 COUNT before refresh");
        quiet(20, "R8 no counting before refresh");
        refresh();
        measure(4 * 8, "R8 new settings active after refresh");

        // R12: reload write mid-count does not change the current countdown
        wr(3'd1, 8'd20);
        wr(3'd0, 8'h21);
        refresh();
        wr(3'd1, 8'd3);
        measure(42 - 2, "R12 reload write deferred");
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h21);
        refresh();
        measure(8, "R12 new reload at next refresh");

        // R11 / R1: power-on reset clears the flag
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_reg(3'd0, 8'h00, "R11 flag cleared by power-on reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule